// File: doc/BRIEF.md
# Memory Access Error Capture Unit

This block sits beside a memory controller and records faulting accesses for three error classes: an address that decodes to no target, an access that hits an invalid translation page, and an access refused by the security checker. Each class has its own fault strobe, carrying the requesting client's 6-bit ID, a write flag, a violation-type flag and the faulting address. When a strobe fires, the block sets a sticky status bit for that class and stores a capture word and the address. Once the status bit is set, the capture registers hold the first fault until software clears the bit.

Software reads the status, mask and capture registers through a simple register port, with a write enable and combinational read data. A status bit is cleared by writing a one to its position. A single interrupt line is high whenever a set status bit is also enabled in the mask register. Each class lays out its capture word differently. In every class the captured address sits in the register 4 bytes above the capture word.

Top module: `errcap_top`

## Requirements
- R1: After reset, status (offset 0x00), mask (0x04), every capture word and every captured address read zero and irq is low.
- R2: A strobe on class 0 (decode error) sets status bit 0. Its capture word at 0x10 holds the client ID in bits 5:0 and the write flag in bit 31, with all other bits zero. The type flag is ignored. The address reads at 0x14.
- R3: A strobe on class 1 (invalid page) sets status bit 1. Its capture word at 0x18 holds the write flag in bit 0 and the client ID in bits 6:1, with all other bits zero. The address reads at 0x1C.
- R4: A strobe on class 2 (security violation) sets status bit 2. Its capture word at 0x20 holds the client ID in bits 5:0, the write flag in bit 31 and the violation-type flag in bit 30. The address reads at 0x24.
- R5: While a class's status bit is set, later strobes of that class change neither its capture word nor its address.
- R6: Writing to 0x00 clears each status bit whose written bit is one. Bits written as zero keep their value. Status bits stay set until cleared.
- R7: The mask at 0x04 is bits 2:0, and its upper bits read zero. irq is high exactly when some status bit and its mask bit are both set. It rises in the cycle after the strobe's clock edge.
- R8: A strobe that arrives in the same cycle as a write clearing its class's bit leaves the bit set and captures the new fault.
- R9: Strobes on different classes in the same cycle are all recorded independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flt_valid | input | 3 | Fault strobe per class (bit 0 decode, 1 page, 2 security) |
| flt_client | input | 18 | Client ID per class, 6 bits each, class 0 lowest |
| flt_write | input | 3 | Write flag per class |
| flt_kind | input | 3 | Violation-type flag per class (used by class 2 only) |
| flt_addr | input | 96 | Faulting address per class, ADDR_W bits each |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| irq | output | 1 | Masked interrupt |

## Verification
A new fault and a software clear of the same status bit can land on the same clock edge. That is the collision R8 decides. The bench provokes it by first leaving a class's bit set with one fault. It then drives a second fault with different ID and address in the same cycle as a status write with that bit at one, and in that cycle also clears another class's bit with no fault present. It judges the result at the ports. The first class's bit must still read set and its capture registers must hold the second fault, while the other class's bit must read zero.

// File: rtl/errcap_pkg.sv
package errcap_pkg;

  localparam int NCLASS = 3;
  localparam int CID_W  = 6;
  localparam int DATA_W = 32;

  typedef enum logic [1:0] {
    CLS_DECODE = 2'd0,
    CLS_PAGE   = 2'd1,
    CLS_SECURE = 2'd2
  } class_e;

  localparam logic [7:0] OFS_STATUS   = 8'h00;
  localparam logic [7:0] OFS_MASK     = 8'h04;
  localparam logic [7:0] OFS_CAP_BASE = 8'h10;
  localparam logic [7:0] OFS_CAP_STEP = 8'h08;

  // Class-specific capture word layout
  function automatic logic [DATA_W-1:0] pack_word(class_e cls, logic [CID_W-1:0] cid,
                                                   logic wr, logic kind);
    logic [DATA_W-1:0] w;
    w = '0;
    case (cls)
      CLS_PAGE: begin
        w[0]       = wr;
        w[CID_W:1] = cid;
      end
      CLS_SECURE: begin
        w[CID_W-1:0] = cid;
        w[31]        = wr;
        w[30]        = kind;
      end
      default: begin
        w[CID_W-1:0] = cid;
        w[31]        = wr;
      end
    endcase
    return w;
  endfunction

endpackage

// File: rtl/errcap_slot.sv
module errcap_slot #(
  parameter errcap_pkg::class_e CLS = errcap_pkg::CLS_DECODE,
  parameter int ADDR_W = 32
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             fault,
  input  logic [errcap_pkg::CID_W-1:0]     cid,
  input  logic                             wr,
  input  logic                             kind,
  input  logic [ADDR_W-1:0]                addr,
  input  logic                             clr,
  output logic                             sts,
  output logic [errcap_pkg::DATA_W-1:0]    cap_word,
  output logic [ADDR_W-1:0]                cap_addr
);

  logic                          sts_q, sts_d;
  logic                          cap_en;
  logic [errcap_pkg::DATA_W-1:0] word_q, word_d;
  logic [ADDR_W-1:0]             addr_q, addr_d;

  always_comb begin
    cap_en = fault & (~sts_q | clr);
    sts_d  = (sts_q & ~clr) | fault;
    word_d = word_q;
    addr_d = addr_q;
    if (cap_en) begin
      word_d = errcap_pkg::pack_word(CLS, cid, wr, kind);
      addr_d = addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q  <= 1'b0;
      word_q <= '0;
      addr_q <= '0;
    end else begin
      sts_q <= sts_d;
      if (cap_en) begin
        word_q <= word_d;
        addr_q <= addr_d;
      end
    end
  end

  assign sts      = sts_q;
  assign cap_word = word_q;
  assign cap_addr = addr_q;

endmodule

// File: rtl/errcap_regs.sv
module errcap_regs #(
  parameter int ADDR_W = 32,
  parameter int REG_AW = 8
) (
  input  logic                                          clk,
  input  logic                                          rst_n,
  input  logic                                          reg_we,
  input  logic [REG_AW-1:0]                             reg_addr,
  input  logic [errcap_pkg::DATA_W-1:0]                 reg_wdata,
  input  logic [errcap_pkg::NCLASS-1:0]                 sts,
  input  logic [errcap_pkg::NCLASS*errcap_pkg::DATA_W-1:0] cap_word,
  input  logic [errcap_pkg::NCLASS*ADDR_W-1:0]          cap_addr,
  output logic [errcap_pkg::NCLASS-1:0]                 clr,
  output logic [errcap_pkg::NCLASS-1:0]                 mask,
  output logic [errcap_pkg::DATA_W-1:0]                 reg_rdata
);
  import errcap_pkg::*;

  localparam int NC = NCLASS;

  logic [NC-1:0] mask_q, mask_d;
  logic          mask_en;
  logic          unused_wdata;
  logic [REG_AW-1:0] a_sts, a_msk;

  assign a_sts = REG_AW'(OFS_STATUS);
  assign a_msk = REG_AW'(OFS_MASK);
  assign unused_wdata = ^reg_wdata[DATA_W-1:NC];

  always_comb begin
    clr     = '0;
    mask_en = 1'b0;
    mask_d  = mask_q;
    if (reg_we && reg_addr == a_sts) clr = reg_wdata[NC-1:0];
    if (reg_we && reg_addr == a_msk) begin
      mask_en = 1'b1;
      mask_d  = reg_wdata[NC-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else if (mask_en) mask_q <= mask_d;
  end

  assign mask = mask_q;

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == a_sts) reg_rdata[NC-1:0] = sts;
    if (reg_addr == a_msk) reg_rdata[NC-1:0] = mask_q;
    for (int i = 0; i < NC; i++) begin
      if (reg_addr == REG_AW'(OFS_CAP_BASE + OFS_CAP_STEP * i))
        reg_rdata = cap_word[i*DATA_W +: DATA_W];
      if (reg_addr == REG_AW'(OFS_CAP_BASE + OFS_CAP_STEP * i + 4)) begin
        reg_rdata = '0;
        reg_rdata[ADDR_W-1:0] = cap_addr[i*ADDR_W +: ADDR_W];
      end
    end
  end

endmodule

// File: rtl/errcap_top.sv
module errcap_top #(
  parameter int ADDR_W = 32,
  parameter int REG_AW = 8
) (
  input  logic                                          clk,
  input  logic                                          rst_n,
  input  logic [errcap_pkg::NCLASS-1:0]                 flt_valid,
  input  logic [errcap_pkg::NCLASS*errcap_pkg::CID_W-1:0] flt_client,
  input  logic [errcap_pkg::NCLASS-1:0]                 flt_write,
  input  logic [errcap_pkg::NCLASS-1:0]                 flt_kind,
  input  logic [errcap_pkg::NCLASS*ADDR_W-1:0]          flt_addr,
  input  logic                                          reg_we,
  input  logic [REG_AW-1:0]                             reg_addr,
  input  logic [errcap_pkg::DATA_W-1:0]                 reg_wdata,
  output logic [errcap_pkg::DATA_W-1:0]                 reg_rdata,
  output logic                                          irq
);
  import errcap_pkg::*;

  logic [NCLASS-1:0]        sts_q;
  logic [NCLASS-1:0]        clr_vec;
  logic [NCLASS-1:0]        mask_q;
  logic [NCLASS*DATA_W-1:0] cap_word;
  logic [NCLASS*ADDR_W-1:0] cap_addr;

  for (genvar g = 0; g < NCLASS; g++) begin : g_slot
    errcap_slot #(
      .CLS    (class_e'(g)),
      .ADDR_W (ADDR_W)
    ) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .fault    (flt_valid[g]),
      .cid      (flt_client[g*CID_W +: CID_W]),
      .wr       (flt_write[g]),
      .kind     (flt_kind[g]),
      .addr     (flt_addr[g*ADDR_W +: ADDR_W]),
      .clr      (clr_vec[g]),
      .sts      (sts_q[g]),
      .cap_word (cap_word[g*DATA_W +: DATA_W]),
      .cap_addr (cap_addr[g*ADDR_W +: ADDR_W])
    );
  end

  errcap_regs #(
    .ADDR_W (ADDR_W),
    .REG_AW (REG_AW)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .sts       (sts_q),
    .cap_word  (cap_word),
    .cap_addr  (cap_addr),
    .clr       (clr_vec),
    .mask      (mask_q),
    .reg_rdata (reg_rdata)
  );

  assign irq = |(sts_q & mask_q);

endmodule

// File: rtl/errcap_chk.sv
module errcap_chk #(
  parameter int ADDR_W = 32
) (
  input logic                                          clk,
  input logic                                          rst_n,
  input logic [errcap_pkg::NCLASS-1:0]                 flt_valid,
  input logic [errcap_pkg::NCLASS-1:0]                 sts,
  input logic [errcap_pkg::NCLASS-1:0]                 clr,
  input logic [errcap_pkg::NCLASS-1:0]                 mask,
  input logic                                          irq,
  input logic [errcap_pkg::NCLASS*errcap_pkg::DATA_W-1:0] cap_word,
  input logic [errcap_pkg::NCLASS*ADDR_W-1:0]          cap_addr
);
  import errcap_pkg::*;

  for (genvar i = 0; i < NCLASS; i++) begin : g_cls
    assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (sts[i] && !clr[i]) |=> sts[i]);

    assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[i] && !flt_valid[i]) |=> !sts[i]);

    assert_fault_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
      flt_valid[i] |=> sts[i]);

    assert_hold_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (sts[i] && !clr[i]) |=> ($stable(cap_word[i*DATA_W +: DATA_W]) &&
                               $stable(cap_addr[i*ADDR_W +: ADDR_W])));
  end

  assert_irq_masked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> !irq);

  assert_irq_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sts == '0) |-> !irq);

endmodule

bind errcap_top errcap_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .flt_valid (flt_valid),
  .sts       (sts_q),
  .clr       (clr_vec),
  .mask      (mask_q),
  .irq       (irq),
  .cap_word  (cap_word),
  .cap_addr  (cap_addr)
);

// File: tb/tb_errcap_top.sv
module tb_errcap_top;

  localparam real CLK_P = 5.0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  flt_valid = '0;
  logic [17:0] flt_client = '0;
  logic [2:0]  flt_write = '0;
  logic [2:0]  flt_kind = '0;
  logic [95:0] flt_addr = '0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;

  always #(CLK_P/2) clk = ~clk;

  errcap_top dut (
    .clk(clk), .rst_n(rst_n), .flt_valid(flt_valid), .flt_client(flt_client),
    .flt_write(flt_write), .flt_kind(flt_kind), .flt_addr(flt_addr),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic rd_chk(string req, logic [7:0] a, logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic set_fault(int c, logic [5:0] cid, logic w, logic k, logic [31:0] a);
    flt_valid[c] = 1'b1;
    flt_client[c*6 +: 6] = cid;
    flt_write[c] = w;
    flt_kind[c] = k;
    flt_addr[c*32 +: 32] = a;
  endtask

  task automatic pulse_faults();
    @(negedge clk);
    @(negedge clk);
    flt_valid = '0;
  endtask

  task automatic t_reset();
    rd_chk("R1 status", 8'h00, 0);
    rd_chk("R1 mask", 8'h04, 0);
    for (int i = 0; i < 3; i++) begin
      rd_chk("R1 capture word", 8'h10 + 8'(8*i), 0);
      rd_chk("R1 capture addr", 8'h14 + 8'(8*i), 0);
    end
    chk("R1 irq", 32'(irq), 0);
  endtask

  task automatic t_decode();
    @(negedge clk);
    set_fault(0, 6'h2A, 1'b1, 1'b1, 32'hDEAD0010);
    pulse_faults();
    chk("R7 irq stays low with mask clear", 32'(irq), 0);
    rd_chk("R2 status bit0", 8'h00, 32'h1);
    rd_chk("R2 decode word", 8'h10, 32'h8000002A);
    rd_chk("R2 decode addr", 8'h14, 32'hDEAD0010);
    wr(8'h04, 32'hFFFFFFFF);
    rd_chk("R7 mask upper bits zero", 8'h04, 32'h7);
    chk("R7 irq with mask set", 32'(irq), 1);
  endtask

  task automatic t_first_fault();
    @(negedge clk);
    set_fault(0, 6'h11, 1'b0, 1'b0, 32'h12345678);
    pulse_faults();
    rd_chk("R5 decode word held", 8'h10, 32'h8000002A);
    rd_chk("R5 decode addr held", 8'h14, 32'hDEAD0010);
  endtask

  task automatic t_clear();
    wr(8'h00, 32'h6);
    rd_chk("R6 zero-bit write keeps status", 8'h00, 32'h1);
    wr(8'h00, 32'h1);
    rd_chk("R6 status cleared", 8'h00, 32'h0);
    chk("R7 irq low after clear", 32'(irq), 0);
  endtask

  task automatic t_page();
    @(negedge clk);
    set_fault(1, 6'h15, 1'b1, 1'b1, 32'hA0B0C0D0);
    @(negedge clk);
    flt_valid = '0;
    chk("R7 irq one cycle after strobe", 32'(irq), 1);
    rd_chk("R3 status bit1", 8'h00, 32'h2);
    rd_chk("R3 page word", 8'h18, 32'h0000002B);
    rd_chk("R3 page addr", 8'h1C, 32'hA0B0C0D0);
    wr(8'h00, 32'h2);
    @(negedge clk);
    set_fault(1, 6'h3F, 1'b0, 1'b0, 32'h00000004);
    pulse_faults();
    rd_chk("R3 page read layout", 8'h18, 32'h0000007E);
    wr(8'h00, 32'h2);
  endtask

  task automatic t_secure();
    @(negedge clk);
    set_fault(2, 6'h07, 1'b0, 1'b1, 32'h55AA55AA);
    pulse_faults();
    rd_chk("R4 secure word type1", 8'h20, 32'h40000007);
    rd_chk("R4 secure addr", 8'h24, 32'h55AA55AA);
    wr(8'h00, 32'h4);
    @(negedge clk);
    set_fault(2, 6'h3F, 1'b1, 1'b0, 32'h0000FFFF);
    pulse_faults();
    rd_chk("R4 secure word type0", 8'h20, 32'h8000003F);
    wr(8'h00, 32'h4);
  endtask

  task automatic t_multi();
    @(negedge clk);
    set_fault(0, 6'h01, 1'b0, 1'b0, 32'h00000100);
    set_fault(1, 6'h02, 1'b0, 1'b0, 32'h00000200);
    set_fault(2, 6'h03, 1'b1, 1'b1, 32'h00000300);
    pulse_faults();
    rd_chk("R9 all status", 8'h00, 32'h7);
    rd_chk("R9 decode word", 8'h10, 32'h00000001);
    rd_chk("R9 page word", 8'h18, 32'h00000004);
    rd_chk("R9 secure word", 8'h20, 32'hC0000003);
    rd_chk("R9 page addr", 8'h1C, 32'h00000200);
  endtask

  task automatic t_collide();
    @(negedge clk);
    set_fault(0, 6'h33, 1'b1, 1'b0, 32'hCAFE0000);
    reg_we = 1'b1; reg_addr = 8'h00; reg_wdata = 32'h3;
    @(negedge clk);
    reg_we = 1'b0;
    flt_valid = '0;
    rd_chk("R8 status after collision", 8'h00, 32'h5);
    rd_chk("R8 new fault captured", 8'h10, 32'h80000033);
    rd_chk("R8 new address captured", 8'h14, 32'hCAFE0000);
    wr(8'h04, 32'h2);
    chk("R7 irq low when set bits are masked", 32'(irq), 0);
  endtask

  initial begin
    #(CLK_P * 100000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_decode();
    t_first_fault();
    t_clear();
    t_page();
    t_secure();
    t_multi();
    t_collide();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule